// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the execute step of a 32-bit integer pipeline for four data-processing operations: add, exclusive-or, a flags-only equivalence test, and reverse subtract with carry. Its inputs are the first register operand, the second operand (already shifted, with the shifter's carry), the opcode, the set-flags bit and the destination register index. The result and the destination write-enable are combinational in the same cycle. The four condition flags (negative, zero, carry, overflow) sit in a register that is loaded on the clock edge.

An instruction takes effect only when the caller marks it valid and its condition check has passed. For logical operations the carry flag comes from the shifter, not from the adder. When the set-flags bit targets the program-counter index, the flag register is loaded from a saved copy supplied by the caller, and the normal flag update does not happen. The register file, fetch and the shifter are outside this block.

Top module: `dpalu_top`

## Requirements
- R1: `opSel` selects the operation: 0 = add (`rnVal + shOp`), 1 = exclusive-or (`rnVal ^ shOp`), 2 = equivalence test (`rnVal ^ shOp`), 3 = reverse subtract with carry (`shOp - rnVal - (1 - C)`, modulo 2^32). `result` is combinational.
- R2: `flags` holds N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. It resets to 0000.
- R3: The equivalence test never raises `rdWrite`. It updates the flags whatever the values of `sBit` and `rdIdx`.
- R4: For an add with flags updated: N is result bit 31, Z is set when the result is zero, C is the adder carry out, and V is set when both operands share a sign and the result sign differs from it.
- R5: For exclusive-or and the equivalence test with flags updated: N and Z are taken from the result, C takes `shCarry`, and V keeps its value.
- R6: For reverse subtract with carry with flags updated: N and Z are taken from the result, and C is NOT borrow, meaning the carry out of `shOp + ~rnVal + C`. V is set when the operands differ in sign and the result sign differs from the sign of `shOp`.
- R7: With `sBit` = 1 and `rdIdx` = 15 on any operation other than the equivalence test, `flags` loads `savedFlags` and `rdWrite` is still raised.
- R8: With `sBit` = 0 on any operation other than the equivalence test, `rdWrite` is raised and `flags` keeps its value.
- R9: When `validIn` or `condPass` is low, `rdWrite` is low and `flags` keeps its value.
- R10: `flags` changes only at a rising clock edge. The carry input of reverse subtract uses the registered C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| validIn | input | 1 | Instruction present this cycle |
| condPass | input | 1 | Condition check passed |
| opSel | input | 2 | Operation code |
| sBit | input | 1 | Set-flags bit |
| rdIdx | input | 4 | Destination register index |
| rnVal | input | 32 | First operand |
| shOp | input | 32 | Shifted second operand |
| shCarry | input | 1 | Shifter carry out |
| savedFlags | input | 4 | Saved status flags (NZCV) |
| result | output | 32 | Operation result |
| rdWrite | output | 1 | Destination write enable |
| flags | output | 4 | Current flags (NZCV) |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 4-bit register index and 15 as the program-counter index. At 32 bits the operand corners 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF can be reached directly, so signed overflow, carry out and a zero result all come up in the random mix. With a 4-bit index, a random destination hits the program-counter code often enough to exercise the restore path, and directed cases cover it as well.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_XOR = 2'd1,
    OP_TEQ = 2'd2,
    OP_RSC = 2'd3
  } aluOp_e;

  // flag bit positions inside the NZCV vector
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int FLAG_W = 4;

  typedef struct packed {
    logic selRsc;         // adder runs shOp + ~rn + C
    logic carryFromShift; // logical op: result from xor, C from shifter
    logic wrDest;         // write destination register
    logic loadFlags;      // normal flag update
    logic restoreFlags;   // copy saved flags into current flags
  } aluStrobe_t;
endpackage

// File: rtl/dpalu_ctrl.sv
module dpalu_ctrl
  import dpalu_pkg::*;
#(
  parameter int REG_IDX_W = 4,
  parameter int PC_IDX    = 15
) (
  input  logic                 validIn,
  input  logic                 condPass,
  input  logic [1:0]           opSel,
  input  logic                 sBit,
  input  logic [REG_IDX_W-1:0] rdIdx,
  output aluStrobe_t           strobe
);
  localparam logic [REG_IDX_W-1:0] PC_CODE = REG_IDX_W'(PC_IDX);

  aluOp_e op;
  logic   live;
  logic   isTeq;
  logic   toPc;

  always_comb begin
    op    = aluOp_e'(opSel);
    live  = validIn && condPass;
    isTeq = (op == OP_TEQ);
    toPc  = sBit && (rdIdx == PC_CODE) && !isTeq;

    strobe.selRsc         = (op == OP_RSC);
    strobe.carryFromShift = (op == OP_XOR) || isTeq;
    strobe.wrDest         = live && !isTeq;
    strobe.restoreFlags   = live && toPc;
    strobe.loadFlags      = live && (isTeq || sBit) && !toPc;
  end
endmodule

// File: rtl/dpalu_datapath.sv
module dpalu_datapath
  import dpalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobe,
  input  logic [WIDTH-1:0]  rnVal,
  input  logic [WIDTH-1:0]  shOp,
  input  logic              shCarry,
  input  logic [FLAG_W-1:0] savedFlags,
  output logic [WIDTH-1:0]  result,
  output logic [FLAG_W-1:0] flags
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0]  opA;
  logic [WIDTH-1:0]  opB;
  logic              cin;
  logic [WIDTH:0]    sumFull;
  logic              ovf;
  logic [FLAG_W-1:0] flagsNext;
  logic [FLAG_W-1:0] flagsQ;

  // one shared adder serves add and reverse subtract with carry
  always_comb begin
    opA     = strobe.selRsc ? shOp : rnVal;
    opB     = strobe.selRsc ? ~rnVal : shOp;
    cin     = strobe.selRsc ? flagsQ[FLAG_C] : 1'b0;
    sumFull = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, cin};
    ovf     = (opA[MSB] == opB[MSB]) && (sumFull[MSB] != opA[MSB]);
    result  = strobe.carryFromShift ? (rnVal ^ shOp) : sumFull[WIDTH-1:0];
  end

  always_comb begin
    flagsNext[FLAG_N] = result[MSB];
    flagsNext[FLAG_Z] = (result == '0);
    flagsNext[FLAG_C] = strobe.carryFromShift ? shCarry : sumFull[WIDTH];
    flagsNext[FLAG_V] = strobe.carryFromShift ? flagsQ[FLAG_V] : ovf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else if (strobe.restoreFlags) begin
      flagsQ <= savedFlags;
    end else if (strobe.loadFlags) begin
      flagsQ <= flagsNext;
    end
  end

  assign flags = flagsQ;
endmodule

// File: rtl/dpalu_top.sv
module dpalu_top
  import dpalu_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int REG_IDX_W = 4,
  parameter int PC_IDX    = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 validIn,
  input  logic                 condPass,
  input  logic [1:0]           opSel,
  input  logic                 sBit,
  input  logic [REG_IDX_W-1:0] rdIdx,
  input  logic [WIDTH-1:0]     rnVal,
  input  logic [WIDTH-1:0]     shOp,
  input  logic                 shCarry,
  input  logic [3:0]           savedFlags,
  output logic [WIDTH-1:0]     result,
  output logic                 rdWrite,
  output logic [3:0]           flags
);
  aluStrobe_t strobe;

  dpalu_ctrl #(
    .REG_IDX_W(REG_IDX_W),
    .PC_IDX   (PC_IDX)
  ) ctrl_i (
    .validIn (validIn),
    .condPass(condPass),
    .opSel   (opSel),
    .sBit    (sBit),
    .rdIdx   (rdIdx),
    .strobe  (strobe)
  );

  dpalu_datapath #(
    .WIDTH(WIDTH)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rnVal     (rnVal),
    .shOp      (shOp),
    .shCarry   (shCarry),
    .savedFlags(savedFlags),
    .result    (result),
    .flags     (flags)
  );

  assign rdWrite = strobe.wrDest;
endmodule

// File: rtl/dpalu_chk.sv
module dpalu_chk #(
  parameter int WIDTH     = 32,
  parameter int REG_IDX_W = 4,
  parameter int PC_IDX    = 15
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 validIn,
  input logic                 condPass,
  input logic [1:0]           opSel,
  input logic                 sBit,
  input logic [REG_IDX_W-1:0] rdIdx,
  input logic                 shCarry,
  input logic [3:0]           savedFlags,
  input logic [WIDTH-1:0]     result,
  input logic                 rdWrite,
  input logic [3:0]           flags
);
  localparam logic [REG_IDX_W-1:0] PC_CODE = REG_IDX_W'(PC_IDX);

  logic live;
  logic toPc;
  assign live = validIn && condPass;
  assign toPc = sBit && (rdIdx == PC_CODE) && (opSel != 2'd2);

  p_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    !live |-> !rdWrite);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !live |=> $stable(flags));

  p_teq_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 2'd2) |-> !rdWrite);

  p_s0_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (live && !sBit && opSel != 2'd2) |=> $stable(flags));

  p_restore_r7: assert property (@(posedge clk) disable iff (!rstN)
    (live && toPc) |=> (flags == $past(savedFlags)));

  p_logic_carry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (live && !toPc && (opSel == 2'd2 || (opSel == 2'd1 && sBit)))
    |=> (flags[1] == $past(shCarry)) && (flags[0] == $past(flags[0])));

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (live && !toPc && (sBit || opSel == 2'd2))
    |=> (flags[2] == ($past(result) == '0)) && (flags[3] == $past(result[WIDTH-1])));
endmodule

bind dpalu_top dpalu_chk #(
  .WIDTH    (WIDTH),
  .REG_IDX_W(REG_IDX_W),
  .PC_IDX   (PC_IDX)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .validIn   (validIn),
  .condPass  (condPass),
  .opSel     (opSel),
  .sBit      (sBit),
  .rdIdx     (rdIdx),
  .shCarry   (shCarry),
  .savedFlags(savedFlags),
  .result    (result),
  .rdWrite   (rdWrite),
  .flags     (flags)
);

// File: tb/dpalu_top_tb_top.sv
`timescale 1ns/1ps
module dpalu_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        validIn, condPass, sBit, shCarry;
  logic [1:0]  opSel;
  logic [3:0]  rdIdx, savedFlags;
  logic [31:0] rnVal, shOp;
  logic [31:0] result;
  logic        rdWrite;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [3:0] mFlags;

  always #2.5 clk = ~clk;

  dpalu_top dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .condPass(condPass),
    .opSel(opSel), .sBit(sBit), .rdIdx(rdIdx), .rnVal(rnVal), .shOp(shOp),
    .shCarry(shCarry), .savedFlags(savedFlags), .result(result),
    .rdWrite(rdWrite), .flags(flags)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [32:0] expSum(input logic [1:0] op, input logic [31:0] rn,
                                          input logic [31:0] sh, input logic c);
    case (op)
      2'd0:    expSum = {1'b0, rn} + {1'b0, sh};
      2'd3:    expSum = {1'b0, sh} + {1'b0, ~rn} + {32'd0, c};
      default: expSum = {1'b0, rn ^ sh};
    endcase
  endfunction

  task automatic runOp(input logic [1:0] op, input logic s, input logic [3:0] rd,
                       input logic [31:0] rn, input logic [31:0] sh, input logic shc,
                       input logic cond, input logic vld, input logic [3:0] saved);
    logic [32:0] full;
    logic [31:0] res;
    logic        expWr, toPc, upd;
    logic [3:0]  nxt;
    string       tag;
    @(negedge clk);
    opSel = op; sBit = s; rdIdx = rd; rnVal = rn; shOp = sh; shCarry = shc;
    condPass = cond; validIn = vld; savedFlags = saved;
    #1;
    full  = expSum(op, rn, sh, mFlags[1]);
    res   = full[31:0];
    expWr = vld && cond && (op != 2'd2);
    check(result == res, "R1", "result", result, res);
    check(rdWrite == expWr, (op == 2'd2) ? "R3" : "R9", "rdWrite",
          {31'd0, rdWrite}, {31'd0, expWr});
    check(flags == mFlags, "R10", "flags before edge", {28'd0, flags}, {28'd0, mFlags});
    toPc = s && (rd == 4'd15) && (op != 2'd2);
    upd  = vld && cond && (s || op == 2'd2);
    nxt  = mFlags;
    if (!(vld && cond)) tag = "R9";
    else if (toPc) begin nxt = saved; tag = "R7"; end
    else if (!upd) tag = "R8";
    else begin
      nxt[3] = res[31];
      nxt[2] = (res == 32'd0);
      if (op == 2'd1 || op == 2'd2) begin
        nxt[1] = shc; tag = "R5";
      end else if (op == 2'd0) begin
        nxt[1] = full[32];
        nxt[0] = (rn[31] == sh[31]) && (res[31] != rn[31]);
        tag = "R4";
      end else begin
        nxt[1] = full[32];
        nxt[0] = (rn[31] != sh[31]) && (res[31] != sh[31]);
        tag = "R6";
      end
    end
    @(posedge clk);
    #1;
    mFlags = nxt;
    check(flags == mFlags, tag, "flags", {28'd0, flags}, {28'd0, mFlags});
  endtask

  function automatic logic [31:0] pickVal();
    case ($urandom % 6)
      0:       pickVal = 32'h0000_0000;
      1:       pickVal = 32'h7FFF_FFFF;
      2:       pickVal = 32'h8000_0000;
      3:       pickVal = 32'hFFFF_FFFF;
      default: pickVal = $urandom;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; validIn = 1'b0; condPass = 1'b0; opSel = 2'd0; sBit = 1'b0;
    rdIdx = 4'd0; rnVal = '0; shOp = '0; shCarry = 1'b0; savedFlags = 4'd0;
    mFlags = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    check(flags == 4'd0, "R2", "reset flags", {28'd0, flags}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R4: signed overflow and carry/zero corners of add
    runOp(2'd0, 1'b1, 4'd1, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1'b1, 4'h0);
    runOp(2'd0, 1'b1, 4'd2, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1'b1, 4'h0);
    runOp(2'd0, 1'b1, 4'd3, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 4'h0);
    // R6: reverse subtract with carry set and clear
    runOp(2'd3, 1'b1, 4'd4, 32'h0000_0001, 32'h0000_0005, 1'b0, 1'b1, 1'b1, 4'h0);
    runOp(2'd3, 1'b1, 4'd4, 32'h0000_0005, 32'h0000_0001, 1'b0, 1'b1, 1'b1, 4'h0);
    runOp(2'd3, 1'b1, 4'd4, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 4'h0);
    // R5: logical carry from shifter, V kept
    runOp(2'd1, 1'b1, 4'd5, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b1, 1'b1, 1'b1, 4'h0);
    // R3: equivalence test with S clear and PC destination still sets flags
    runOp(2'd2, 1'b0, 4'd15, 32'h1234_5678, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 4'hF);
    // R7: restore from saved flags
    runOp(2'd0, 1'b1, 4'd15, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b1, 1'b1, 4'hA);
    runOp(2'd3, 1'b1, 4'd15, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b1, 1'b1, 4'h5);
    // R8: S clear leaves flags
    runOp(2'd0, 1'b0, 4'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 4'h0);
    // R9: condition fail and invalid
    runOp(2'd1, 1'b1, 4'd7, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 4'hF);
    runOp(2'd2, 1'b1, 4'd15, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 4'hF);

    for (int i = 0; i < 600; i++) begin
      runOp(2'($urandom), 1'($urandom), 4'($urandom), pickVal(), pickVal(),
            1'($urandom), ($urandom % 8) != 0, ($urandom % 8) != 0, 4'($urandom));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule